// File: doc/BRIEF.md
# UART Interrupt Priority Arbiter

This block sits beside the register file of a 16450/16550-style serial port. It decides which interrupt cause is shown to software and drives the single interrupt request line. Five causes feed it, each as a one-cycle event pulse from the logic that detects it:

- a receive line error (overrun, parity, framing or break)
- received data reaching the trigger level
- a character timeout
- the transmit holding register becoming empty
- a modem status change

The arbiter latches one pending bit per cause. It keeps a copy of the interrupt enable value. Each pending bit is cleared by the register access that serves that cause.

On every clock edge the block selects the highest-priority cause that is both pending and enabled. It then updates the identification code, which is the value software reads to learn the cause. Because selection runs on every edge, the code follows every clear and every enable write. When the active cause clears, the next one is shown, or the "no interrupt" code if nothing is left. The timeout cause shares the received-data enable. A read of the identification register clears the transmit-empty cause only while that cause is the one shown.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset, the code is 0x1 (no interrupt), `irq` is low and every pending bit is zero. Enabling all causes straight after reset therefore still shows 0x1.
- R2: Priority runs, highest first: line error, received data, character timeout, transmit empty, modem status. The code shown is that of the highest cause that is both pending and enabled.
- R3: The character timeout cause is enabled by the received-data enable bit (bit 0) and has no enable bit of its own.
- R4: Enable bits are: bit 0 received data and timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem status. A cause that arrives while disabled stays pending and is shown once it is enabled.
- R5: Pending bits are cleared as follows:
  - a line status read (`lsr_rd`) clears line error;
  - a receive data read (`rbr_rd`) clears both received data and timeout;
  - a modem status read (`msr_rd`) clears modem status;
  - a transmit holding write (`thr_wr`) clears transmit empty.
- R6: An identification read (`iir_rd`) clears transmit empty only when the current code is 0x2. At any other code it leaves transmit empty pending.
- R7: `iir_rdata` equals the current code in bits 3:0, zeros in bits 5:4 and ones in bits 7:6.
- R8: `irq` is high exactly while the code is not 0x1.
- R9: Code values are: 0x6 line error, 0x4 received data, 0xC timeout, 0x2 transmit empty, 0x0 modem status, 0x1 none.
- R10: The code reflects events, clears and enable writes from the edge at which they are sampled. The enable value used is the newly written one. When an event pulse and a clear of the same cause arrive in the same cycle, the event wins and the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_line_err | input | 1 | Pulse: receive line error detected |
| ev_rx_data | input | 1 | Pulse: receive fill reached the trigger level |
| ev_rx_timeout | input | 1 | Pulse: character timeout expired |
| ev_tx_empty | input | 1 | Pulse: transmit holding register became empty |
| ev_modem | input | 1 | Pulse: modem status change |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable value written |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive data read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iid | output | 4 | Current identification code |
| iir_rdata | output | 8 | Identification read value |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at these cases:

- **Identification read at a non-empty code.** A design that cleared transmit empty on any identification read would lose a transmit-empty interrupt that is hidden behind a higher cause.
- **Timeout arriving while only bit 0 is enabled.** A design that gave the timeout its own enable bit would never report it in this case.
- **Causes arriving while disabled.** The bench enables them later. A design that dropped such causes would stay at 0x1.
- **An event and its own clear in the same cycle.** A design that let the clear win would lose the event.

Random mixes of events, clears and enable writes check that the priority order holds after every clear.

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter #(
  parameter int ENW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_line_err,
  input  logic           ev_rx_data,
  input  logic           ev_rx_timeout,
  input  logic           ev_tx_empty,
  input  logic           ev_modem,
  input  logic           ier_wr,
  input  logic [ENW-1:0] ier_wdata,
  input  logic           lsr_rd,
  input  logic           rbr_rd,
  input  logic           msr_rd,
  input  logic           iir_rd,
  input  logic           thr_wr,
  output logic [3:0]     iid,
  output logic [7:0]     iir_rdata,
  output logic           irq
);
  localparam logic [3:0] C_NONE = 4'h1, C_LS = 4'h6, C_RD = 4'h4,
                         C_TO = 4'hC, C_TH = 4'h2, C_MS = 4'h0;

  // pending order: [4] line err, [3] rx data, [2] timeout, [1] tx empty, [0] modem
  logic [4:0]     pend_q, pend_d, set_v, clr_v, act;
  logic [ENW-1:0] ier_q, ier_d;
  logic [3:0]     code_q, code_d;

  assign ier_d = ier_wr ? ier_wdata : ier_q;
  assign set_v = {ev_line_err, ev_rx_data, ev_rx_timeout, ev_tx_empty, ev_modem};
  assign clr_v = {lsr_rd, rbr_rd, rbr_rd, thr_wr | (iir_rd && code_q == C_TH), msr_rd};
  assign pend_d = (pend_q & ~clr_v) | set_v;
  assign act = pend_d & {ier_d[2], ier_d[0], ier_d[0], ier_d[1], ier_d[3]};

  always_comb begin
    if      (act[4]) code_d = C_LS;
    else if (act[3]) code_d = C_RD;
    else if (act[2]) code_d = C_TO;
    else if (act[1]) code_d = C_TH;
    else if (act[0]) code_d = C_MS;
    else             code_d = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ier_q  <= '0;
      code_q <= C_NONE;
    end else begin
      pend_q <= pend_d;
      ier_q  <= ier_d;
      code_q <= code_d;
    end
  end

  assign iid       = code_q;
  assign iir_rdata = {2'b11, 2'b00, code_q};
  assign irq       = (code_q != C_NONE);

  // R2
  line_err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_line_err && !ier_wr && ier_q[2]) |=> (iid == C_LS));

  // R6
  iir_rd_thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iid == C_TH && !ev_tx_empty) |=> !pend_q[1]);

  // R6
  iir_rd_keep_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iid != C_TH && !thr_wr && pend_q[1]) |=> pend_q[1]);

  // R5
  rbr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !ev_rx_data && !ev_rx_timeout) |=> (pend_q[3:2] == 2'b00));

  // R3
  timeout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iid == C_TO) |-> (ier_q[0] && pend_q[2]));

  // R10
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_modem && msr_rd) |=> pend_q[0]);
endmodule

// File: tb/uart_irq_arbiter_tb_top.sv
module uart_irq_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_ls = 0, ev_rd = 0, ev_to = 0, ev_th = 0, ev_ms = 0;
  logic ier_wr = 0;
  logic [3:0] ier_wdata = '0;
  logic lsr_rd = 0, rbr_rd = 0, msr_rd = 0, iir_rd = 0, thr_wr = 0;
  logic [3:0] iid;
  logic [7:0] iir_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] m_pend = '0;
  logic [3:0] m_ier = '0;
  logic [3:0] m_code = 4'h1;

  always #2.5 clk = ~clk;

  uart_irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_line_err(ev_ls), .ev_rx_data(ev_rd), .ev_rx_timeout(ev_to),
    .ev_tx_empty(ev_th), .ev_modem(ev_ms),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .msr_rd(msr_rd), .iir_rd(iir_rd), .thr_wr(thr_wr),
    .iid(iid), .iir_rdata(iir_rdata), .irq(irq)
  );

  function automatic logic [3:0] code_of(logic [4:0] p, logic [3:0] en);
    logic [4:0] a;
    a = p & {en[2], en[0], en[0], en[1], en[3]};
    if (a[4]) return 4'h6;
    if (a[3]) return 4'h4;
    if (a[2]) return 4'hC;
    if (a[1]) return 4'h2;
    if (a[0]) return 4'h0;
    return 4'h1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    {ev_ls, ev_rd, ev_to, ev_th, ev_ms} = '0;
    {ier_wr, lsr_rd, rbr_rd, msr_rd, iir_rd, thr_wr} = '0;
    ier_wdata = '0;
  endtask

  // inputs already driven (at negedge); check, clock, check
  task automatic cyc(string tag);
    logic [4:0] clr, set;
    logic [3:0] ier_n;
    #1;
    chk({tag, " R7 read value"}, iir_rdata, {4'b1100, m_code});
    set = {ev_ls, ev_rd, ev_to, ev_th, ev_ms};
    clr = {lsr_rd, rbr_rd, rbr_rd, thr_wr | (iir_rd && m_code == 4'h2), msr_rd};
    ier_n = ier_wr ? ier_wdata : m_ier;
    m_pend = (m_pend & ~clr) | set;
    m_ier = ier_n;
    m_code = code_of(m_pend, m_ier);
    @(negedge clk);
    chk({tag, " R2/R9 code"}, {4'h0, iid}, {4'h0, m_code});
    chk({tag, " R8 irq"}, {7'h0, irq}, {7'h0, m_code != 4'h1});
    clear_in();
  endtask

  task automatic wr_ier(logic [3:0] v, string tag);
    ier_wr = 1; ier_wdata = v; cyc(tag);
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset code", {4'h0, iid}, 8'h01);
    chk("R1 reset irq", {7'h0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    wr_ier(4'hF, "R1 enable all after reset");
    chk("R1 no pending after reset", {4'h0, iid}, 8'h01);

    // R3: timeout seen with only bit 0 enabled
    wr_ier(4'h1, "R3 setup");
    ev_to = 1; cyc("R3 timeout");
    chk("R3 timeout code", {4'h0, iid}, 8'h0C);
    rbr_rd = 1; cyc("R5 rbr read clears timeout");
    chk("R5 timeout cleared", {4'h0, iid}, 8'h01);

    // R4: pending while disabled, shown later
    wr_ier(4'h0, "R4 disable");
    ev_ms = 1; ev_th = 1; cyc("R4 events while disabled");
    chk("R4 disabled shows none", {4'h0, iid}, 8'h01);
    wr_ier(4'h8, "R4 enable modem");
    chk("R4 modem shown", {4'h0, iid}, 8'h00);
    wr_ier(4'hA, "R4 enable tx empty");
    chk("R2 tx empty over modem", {4'h0, iid}, 8'h02);

    // R6: identification read at non-thr code leaves tx empty pending
    ev_ls = 1; ier_wr = 1; ier_wdata = 4'hE; cyc("R6 setup");
    chk("R2 line err top", {4'h0, iid}, 8'h06);
    iir_rd = 1; cyc("R6 read at line err");
    lsr_rd = 1; cyc("R5 lsr clears line err");
    chk("R6 tx empty still pending", {4'h0, iid}, 8'h02);
    iir_rd = 1; cyc("R6 read at tx empty");
    chk("R6 tx empty cleared by read", {4'h0, iid}, 8'h00);

    // R10: event and clear together, event wins
    ev_ms = 1; msr_rd = 1; cyc("R10 set and clear");
    chk("R10 modem still shown", {4'h0, iid}, 8'h00);
    msr_rd = 1; cyc("R5 msr clears modem");
    chk("R5 modem cleared", {4'h0, iid}, 8'h01);
    ev_th = 1; cyc("R5 thr setup");
    thr_wr = 1; cyc("R5 thr write clears");
    chk("R5 thr cleared", {4'h0, iid}, 8'h01);
    ev_rd = 1; ev_to = 1; cyc("R2 rd over timeout");
    wr_ier(4'h1, "R2 rd");
    chk("R2 rx data over timeout", {4'h0, iid}, 8'h04);
    rbr_rd = 1; cyc("R5 rbr clears both");

    for (int i = 0; i < 4000; i++) begin
      ev_ls = ($urandom % 7) == 0;
      ev_rd = ($urandom % 7) == 0;
      ev_to = ($urandom % 7) == 0;
      ev_th = ($urandom % 7) == 0;
      ev_ms = ($urandom % 7) == 0;
      lsr_rd = ($urandom % 6) == 0;
      rbr_rd = ($urandom % 6) == 0;
      msr_rd = ($urandom % 6) == 0;
      iir_rd = ($urandom % 4) == 0;
      thr_wr = ($urandom % 8) == 0;
      ier_wr = ($urandom % 10) == 0;
      ier_wdata = 4'($urandom);
      cyc("random R2 R4 R5 R6");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule